// File: doc/BRIEF.md
# Page Translation Unit

This block turns a 32-bit virtual address into a physical address using 4 KB pages. The upper part of the address selects an entry in a small on-chip page table held in flops. The entry supplies the physical page number. The low 12 bits, the offset within the page, pass through unchanged. Each entry also carries a present flag, read, write and execute permissions, used and dirty bookkeeping flags, and an I/O attribute.

A request names the address and the kind of access. One cycle later the block returns either the physical address or a fault code. It checks the present flag first and the permissions second. In the same edge that captures a successful result, it sets the entry's used flag, and for a write it also sets the dirty flag. A separate load port writes whole entries, so software or a table walker can fill and change the table. Each response also reports the entry's I/O attribute and the used and dirty flags as they stood before the access. These reported flags let a page-replacement agent see the bookkeeping state.

Top module: `page_xlate`

## Requirements
- R1: A response (`rsp_valid_o` high) appears exactly one clock cycle after every cycle with `req_valid_i` high, and in no other cycle. Requests may arrive back to back.
- R2: On a response without a fault, `rsp_pa_o` equals the entry's 20-bit physical page number followed by the request's low 12 address bits, copied unchanged.
- R3: A load (`ld_en_i` high) replaces the entry at `ld_idx_i` with `ld_pte_i`. The bit layout is:
  - bits 19:0 hold the physical page number.
  - bit 20 is present.
  - bit 21 is read allowed.
  - bit 22 is write allowed.
  - bit 23 is execute allowed.
  - bit 24 is used.
  - bit 25 is dirty.
  - bit 26 is I/O.
  - bits 31:27 are unused.

  Reset clears every entry, so every page reads as not present.
- R4: If the selected entry's present bit is clear, the response carries fault code 1 (not present), and `rsp_pa_o` is zero. A fault-free response carries code 0.
- R5: A virtual page number of 64 or more lies outside the table and gives fault code 1. Page 63 translates normally.
- R6: The access kind on `req_kind_i` selects the permission to check:
  - 0 needs read.
  - 1 needs write.
  - 2 needs execute.
  - 3 is treated as a read.

  A present page without the needed permission gives fault code 2 and a zero address. When a page is not present, code 1 takes precedence over code 2.
- R7: A fault-free access sets the entry's used bit, and a fault-free write also sets its dirty bit. A faulting access changes neither bit.
- R8: For a page number inside the table, a response reports the entry's I/O bit, used bit and dirty bit as they were before this access took effect. For a page number outside the table, all three are zero.
- R9: When a load and a translation hit the same entry in the same cycle, the translation uses the old contents. The loaded value then replaces the entry, including its used and dirty bits, and the bookkeeping update from that translation is dropped.
- R10: During and right after reset, `rsp_valid_o`, `rsp_pa_o`, `rsp_fault_o` and the reported flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| ld_en_i | input | 1 | Entry load strobe |
| ld_idx_i | input | 6 | Entry index to load |
| ld_pte_i | input | 32 | Entry value to load |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_pa_o | output | 32 | Physical address, zero on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 not present, 2 permission |
| rsp_io_o | output | 1 | I/O attribute of the entry |
| rsp_was_used_o | output | 1 | Used bit before this access |
| rsp_was_dirty_o | output | 1 | Dirty bit before this access |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 12-bit offset and 64 entries. With these values it can reach the last valid page, 63, the first page outside the table, 64, and the top page of the address space. A shadow copy of the table in the bench predicts each response, including the flags that earlier accesses set. This lets the bench check the reported flags and the effect of faulting accesses on later responses, and it covers the case of a load and a translation to the same entry in the same cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int PTE_W = 32;
  localparam int PPN_W = 20;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PERM   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic [4:0]       rsvd;
    logic             io;
    logic             dirty;
    logic             used;
    logic             ex;
    logic             wr;
    logic             rd;
    logic             present;
    logic [PPN_W-1:0] ppn;
  } pte_t;
endpackage

// File: rtl/pte_table.sv
module pte_table
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output pte_t             rd_entry_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_set_used_i,
  input  logic             upd_set_dirty_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  pte_t             ld_entry_i
);
  pte_t mem_q [ENTRIES];
  logic upd_blocked;

  assign upd_blocked = ld_en_i && (ld_idx_i == upd_idx_i);
  assign rd_entry_o  = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else begin
      if (upd_en_i && !upd_blocked) begin
        mem_q[upd_idx_i].used  <= mem_q[upd_idx_i].used | upd_set_used_i;
        mem_q[upd_idx_i].dirty <= mem_q[upd_idx_i].dirty | upd_set_dirty_i;
      end
      if (ld_en_i) mem_q[ld_idx_i] <= ld_entry_i;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> mem_q[$past(ld_idx_i)] == $past(ld_entry_i)); // R9
  AST_USED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_set_used_i && !upd_blocked) |=> mem_q[$past(upd_idx_i)].used); // R7
  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_set_dirty_i && !upd_blocked) |=> mem_q[$past(upd_idx_i)].dirty); // R7
endmodule

// File: rtl/access_check.sv
module access_check
  import xlate_pkg::*;
(
  input  pte_t        entry_i,
  input  logic        in_range_i,
  input  logic [1:0]  kind_i,
  output fault_e      fault_o,
  output logic        set_used_o,
  output logic        set_dirty_o
);
  logic allow;

  always_comb begin
    unique case (access_e'(kind_i))
      ACC_WRITE: allow = entry_i.wr;
      ACC_EXEC:  allow = entry_i.ex;
      default:   allow = entry_i.rd;
    endcase
    if (!in_range_i || !entry_i.present) fault_o = FLT_ABSENT;
    else if (!allow)                     fault_o = FLT_PERM;
    else                                 fault_o = FLT_NONE;
    set_used_o  = (fault_o == FLT_NONE);
    set_dirty_o = set_used_o && (access_e'(kind_i) == ACC_WRITE);
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int ENTRIES  = 64,
  localparam int VPN_W   = VA_W - OFFSET_W,
  localparam int PA_W    = PPN_W + OFFSET_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [1:0]       req_kind_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [PTE_W-1:0] ld_pte_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_fault_o,
  output logic             rsp_io_o,
  output logic             rsp_was_used_o,
  output logic             rsp_was_dirty_o
);
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  pte_t             entry;
  fault_e           fault;
  logic             set_used, set_dirty;

  assign vpn      = req_va_i[VA_W-1:OFFSET_W];
  assign idx      = vpn[IDX_W-1:0];
  assign in_range = (vpn < VPN_W'(ENTRIES));

  pte_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_idx_i        (idx),
    .rd_entry_o      (entry),
    .upd_en_i        (req_valid_i && in_range),
    .upd_idx_i       (idx),
    .upd_set_used_i  (set_used),
    .upd_set_dirty_i (set_dirty),
    .ld_en_i         (ld_en_i),
    .ld_idx_i        (ld_idx_i),
    .ld_entry_i      (pte_t'(ld_pte_i))
  );

  access_check u_check (
    .entry_i     (entry),
    .in_range_i  (in_range),
    .kind_i      (req_kind_i),
    .fault_o     (fault),
    .set_used_o  (set_used),
    .set_dirty_o (set_dirty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_pa_o        <= '0;
      rsp_fault_o     <= FLT_NONE;
      rsp_io_o        <= 1'b0;
      rsp_was_used_o  <= 1'b0;
      rsp_was_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o     <= req_valid_i;
      rsp_pa_o        <= '0;
      rsp_fault_o     <= FLT_NONE;
      rsp_io_o        <= 1'b0;
      rsp_was_used_o  <= 1'b0;
      rsp_was_dirty_o <= 1'b0;
      if (req_valid_i) begin
        rsp_fault_o <= fault;
        if (fault == FLT_NONE) rsp_pa_o <= {entry.ppn, req_va_i[OFFSET_W-1:0]};
        if (in_range) begin
          rsp_io_o        <= entry.io;
          rsp_was_used_o  <= entry.used;
          rsp_was_dirty_o <= entry.dirty;
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o != FLT_NONE ||
                     rsp_pa_o[OFFSET_W-1:0] == $past(req_va_i[OFFSET_W-1:0]))); // R2
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> rsp_pa_o == '0); // R4
  AST_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !in_range) |=> rsp_fault_o == FLT_ABSENT); // R5
  AST_FAULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o != 2'd3); // R6
endmodule

// File: tb/page_xlate_test.sv
module page_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        ld_en = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic [31:0] ld_pte = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        rsp_io, rsp_used, rsp_dirty;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  logic [31:0] model [64];

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  flt;
    logic        io, used, dirty;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t q[$];

  page_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_kind_i(req_kind),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_pte_i(ld_pte),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault),
    .rsp_io_o(rsp_io), .rsp_was_used_o(rsp_used), .rsp_was_dirty_o(rsp_dirty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [31:0] mk(input logic [19:0] ppn, input bit p, rd, wr, ex, io);
    return {5'b0, io, 1'b0, 1'b0, ex, wr, rd, p, ppn};
  endfunction

  // Driver: one request (optionally with a load) per call, expected item queued.
  task automatic send(input logic [31:0] va, input logic [1:0] kind, input string tag,
                      input bit with_ld = 0, input logic [5:0] li = 0, input logic [31:0] lp = 0);
    exp_t e;
    logic [19:0] vpn;
    logic [31:0] ent;
    bit allow;
    @(negedge clk);
    req_valid = 1; req_va = va; req_kind = kind;
    ld_en = with_ld; ld_idx = li; ld_pte = lp;
    vpn = va[31:12];
    e.tag = tag; e.cyc = cycle; e.pa = 0; e.io = 0; e.used = 0; e.dirty = 0;
    if (vpn >= 64) e.flt = 1;
    else begin
      ent = model[vpn[5:0]];
      e.io = ent[26]; e.used = ent[24]; e.dirty = ent[25];
      allow = (kind == 2'd1) ? ent[22] : (kind == 2'd2) ? ent[23] : ent[21];
      e.flt = !ent[20] ? 2'd1 : (allow ? 2'd0 : 2'd2);
      if (e.flt == 0) begin
        e.pa = {ent[19:0], va[11:0]};
        model[vpn[5:0]][24] = 1'b1;
        if (kind == 2'd1) model[vpn[5:0]][25] = 1'b1;
      end
    end
    if (with_ld) model[li] = lp;
    q.push_back(e);
  endtask

  task automatic load(input logic [5:0] li, input logic [31:0] lp);
    @(negedge clk);
    req_valid = 0; ld_en = 1; ld_idx = li; ld_pte = lp;
    model[li] = lp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; ld_en = 0;
    end
  endtask

  // Monitor: compare responses against queued expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].cyc + 1 == cycle) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (!rsp_valid || rsp_pa !== e.pa || rsp_fault !== e.flt || rsp_io !== e.io ||
            rsp_used !== e.used || rsp_dirty !== e.dirty) begin
          failures++;
          $display("FAIL %s: got v=%0b pa=%h f=%0d io=%0b u=%0b d=%0b exp v=1 pa=%h f=%0d io=%0b u=%0b d=%0b",
                   e.tag, rsp_valid, rsp_pa, rsp_fault, rsp_io, rsp_used, rsp_dirty,
                   e.pa, e.flt, e.io, e.used, e.dirty);
        end
      end else if (rsp_valid) begin
        checks++; failures++;
        $display("FAIL R1: got rsp_valid=1 exp rsp_valid=0");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (rsp_valid !== 0 || rsp_pa !== 0 || rsp_fault !== 0 || rsp_io !== 0 || rsp_used !== 0 || rsp_dirty !== 0) begin
      failures++;
      $display("FAIL R10: got v=%0b pa=%h f=%0d exp all zero", rsp_valid, rsp_pa, rsp_fault);
    end
    rst_n = 1;
    idle(2);
    send(32'h0000_0ABC, 0, "R3 reset clears table");
    load(1, mk(20'hABCDE, 1, 1, 1, 0, 1));
    send(32'h0000_1123, 0, "R2 first read");
    send(32'h0000_1FFF, 0, "R7 used set by read");
    send(32'h0000_1000, 1, "R7 write ok");
    send(32'h0000_1456, 3, "R6 kind 3 as read, R7 dirty seen");
    send(32'h0000_1010, 2, "R6 exec denied");
    idle(1);
    load(5, mk(20'h00055, 1, 1, 0, 0, 0));
    send(32'h0000_5004, 1, "R6 write denied");
    send(32'h0000_5008, 0, "R7 faulting write left flags");
    load(6, mk(20'h12345, 1, 0, 0, 1, 0));
    send(32'h0000_6800, 0, "R6 read denied on exec-only");
    send(32'h0000_6804, 2, "R6 exec allowed");
    load(9, mk(20'hFFFFF, 0, 1, 1, 1, 1));
    send(32'h0000_9ABC, 1, "R4 not present wins");
    load(10, mk(20'h00AAA, 0, 0, 0, 0, 0));
    send(32'h0000_A000, 2, "R4 absent no perms");
    load(63, mk(20'h3F3F3, 1, 1, 1, 1, 0));
    send(32'h0003_FFFF, 0, "R5 last page");
    send(32'h0004_0000, 0, "R5 page 64");
    send(32'hFFFF_FFFF, 1, "R5 top page");
    load(7, mk(20'h00777, 1, 1, 0, 0, 0));
    send(32'h0000_7321, 0, "R9 old contents", 1, 7, mk(20'h11111, 1, 1, 1, 0, 1));
    send(32'h0000_7321, 0, "R9 load overrides update");
    for (int p = 20; p < 30; p++) load(6'(p), mk(20'(p * 32'h01357 + 3), 1, 1, 1, 0, p[0]));
    for (int p = 20; p < 30; p++) send({12'h0, 8'(p), 12'(p * 97)}, 2'(p % 2), "R2 sweep");
    for (int p = 20; p < 30; p++) send({12'h0, 8'(p), 12'hFFF - 12'(p)}, 0, "R8 flags after sweep");
    idle(4);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R1: got %0d pending exp 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule